// File: doc/BRIEF.md
# Boot kernel byte packing loader

This block brings a fixed-length boot kernel in from a byte-wide external memory port and stores it in an internal memory built from 16-bit columns. The incoming bytes are gathered four at a time, with the earliest byte taking the lowest position, into 32-bit words. Each 32-bit word is written across two neighbouring columns. Once the full kernel is stored, a sequencer-side port reads the same columns three at a time and returns 48-bit instruction words. Because the fill width and the fetch width differ, instruction boundaries land in the middle of transfer words on every odd instruction.

After reset the loader is idle and holds the processor core in its idle state. It waits for a start pulse. It then accepts bytes through a valid/ready handshake until `N_INSTR * 6` bytes have arrived; shorter kernels must be padded with no-op instructions before they are sent. Completion raises a one-cycle interrupt pulse and a done level that releases the core. Fetches of instruction addresses `BASE_ADDR` to `BASE_ADDR + N_INSTR - 1` return the stored words one cycle after the request. A fetch made before completion, or outside that window, returns zero and flags an error.

Top module: `kernel_boot_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the loader returns to idle. After that edge `byte_ready`, `done_irq`, `done_sticky`, `fetch_valid` and `fetch_err` are 0, `fetch_data` is 0 and `core_idle` is 1.
- R2: In the idle state a `start` pulse makes `byte_ready` go to 1 from the following cycle. Before that, no byte is taken.
- R3: Bytes are packed little-end first. Byte 4n+j of the stream lands in bits 8j+7..8j of packed word n. Bits 15..0 of word n fill column 2n and bits 31..16 fill column 2n+1.
- R4: A byte is taken only in a cycle with both `byte_valid` and `byte_ready` high. Cycles with `byte_valid` low lose no byte and duplicate no byte.
- R5: The load takes exactly `N_INSTR*3/2` packed words, which is `N_INSTR*6` bytes. After the last byte is taken, `byte_ready` is 0 from the next cycle on, and further bytes have no effect.
- R6: `core_idle` is 1 from reset until the cycle after the last byte is taken. It is 0 from then until the next reset.
- R7: `done_irq` is 1 for exactly one cycle, in the cycle after the last byte is taken. `done_sticky` rises in that same cycle and stays 1 until reset.
- R8: A `fetch_req` with `fetch_addr = BASE_ADDR + k`, where 0 ≤ k < `N_INSTR`, made while `done_sticky` is 1, gives `fetch_valid = 1` in the next cycle. In that cycle `fetch_data` holds columns 3k, 3k+1 and 3k+2, with column 3k in bits 15..0. These are bytes 6k to 6k+5 of the stream, with the lowest-numbered byte in the least significant position.
- R9: A `fetch_req` made while `done_sticky` is 0 gives `fetch_valid = 1`, `fetch_err = 1` and `fetch_data = 0` in the next cycle.
- R10: A `fetch_req` with an address below `BASE_ADDR`, or at or above `BASE_ADDR + N_INSTR`, gives `fetch_err = 1` and `fetch_data = 0` in the next cycle, even after completion.
- R11: A `start` pulse during loading or after completion has no effect. The byte count, `byte_ready` and `done_sticky` carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, acted on only in the idle state |
| byte_valid | input | 1 | External memory presents a byte |
| byte_data | input | 8 | Byte from external memory |
| byte_ready | output | 1 | Loader accepts a byte this cycle |
| core_idle | output | 1 | Holds the processor core idle |
| done_irq | output | 1 | One-cycle completion interrupt |
| done_sticky | output | 1 | Completion level, held until reset |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | ADDR_W | Instruction address of the fetch |
| fetch_valid | output | 1 | Fetch response present |
| fetch_data | output | 48 | Fetched instruction word |
| fetch_err | output | 1 | Fetch was early or out of range |

## Verification
The bench builds the loader with its defaults: `N_INSTR = 256`, `ADDR_W = 20` and `BASE_ADDR = 0x90000`. With these values it streams the full 1536-byte kernel, with stalls at random byte positions. It then fetches every one of the 256 instructions, so both the word-aligned even instructions and the odd instructions that straddle a packed word are covered, along with the last column of storage. The 20-bit address also lets the bench probe the addresses just below the window, just above it, and far outside it.

// File: rtl/kernel_boot_loader.sv
module kernel_boot_loader #(
  parameter int N_INSTR = 256,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h90000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              core_idle,
  output logic              done_irq,
  output logic              done_sticky,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic [47:0]       fetch_data,
  output logic              fetch_err
);
  localparam int N_WORDS = N_INSTR * 3 / 2;
  localparam int N_COLS  = N_INSTR * 3;
  localparam int WCNT_W  = $clog2(N_WORDS);
  localparam int ICNT_W  = $clog2(N_INSTR);
  localparam int COL_W   = WCNT_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DONE} state_t;
  state_t state;

  logic [1:0]        lane;
  logic [WCNT_W-1:0] wcnt;
  logic [23:0]       acc;
  logic [15:0]       cols [N_COLS];

  logic take, word_end, last_word;
  assign take      = byte_valid && byte_ready;
  assign word_end  = take && (lane == 2'd3);
  assign last_word = wcnt == WCNT_W'(N_WORDS - 1);

  assign byte_ready = state == S_LOAD;
  assign core_idle  = !done_sticky;

  logic [ADDR_W-1:0] off;
  logic              in_range, fetch_ok;
  logic [COL_W-1:0]  cb;
  assign off      = fetch_addr - BASE_ADDR;
  assign in_range = off < ADDR_W'(N_INSTR);
  assign fetch_ok = fetch_req && done_sticky && in_range;
  assign cb       = COL_W'(32'(off[ICNT_W-1:0]) * 32'd3);

  always_ff @(posedge clk) begin
    if (word_end) begin
      cols[{wcnt, 1'b0}] <= acc[15:0];
      cols[{wcnt, 1'b1}] <= {byte_data, acc[23:16]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      lane        <= '0;
      wcnt        <= '0;
      acc         <= '0;
      done_irq    <= 1'b0;
      done_sticky <= 1'b0;
      fetch_valid <= 1'b0;
      fetch_err   <= 1'b0;
      fetch_data  <= '0;
    end else begin
      done_irq <= 1'b0;
      case (state)
        S_IDLE: if (start) state <= S_LOAD;
        S_LOAD: if (take) begin
          lane <= lane + 2'd1;
          case (lane)
            2'd0: acc[7:0]   <= byte_data;
            2'd1: acc[15:8]  <= byte_data;
            2'd2: acc[23:16] <= byte_data;
            default: ;
          endcase
          if (word_end) begin
            wcnt <= wcnt + WCNT_W'(1);
            if (last_word) begin
              state       <= S_DONE;
              done_sticky <= 1'b1;
              done_irq    <= 1'b1;
            end
          end
        end
        default: ;
      endcase
      fetch_valid <= fetch_req;
      fetch_err   <= fetch_req && !fetch_ok;
      fetch_data  <= fetch_ok ? {cols[cb + COL_W'(2)], cols[cb + COL_W'(1)], cols[cb]} : '0;
    end
  end

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
    done_sticky |=> done_sticky);
  assert_irq_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_sticky) |-> done_irq);
  assert_core_held_R6: assert property (@(posedge clk) disable iff (rst)
    byte_ready |-> core_idle);
  assert_no_take_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    done_sticky |-> !byte_ready);
  assert_stall_keeps_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_ready && !byte_valid) |=> $stable(lane) && $stable(wcnt));
  assert_early_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !done_sticky) |=> fetch_err && fetch_valid);
  assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (rst)
    fetch_err |-> fetch_data == '0);
endmodule

// File: tb/kernel_boot_loader_tb.sv
module kernel_boot_loader_tb_top;
  localparam int N_INSTR = 256;
  localparam int N_BYTES = N_INSTR * 6;
  localparam logic [19:0] BASE = 20'h90000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, byte_valid = 1'b0, fetch_req = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [19:0] fetch_addr = '0;
  logic        byte_ready, core_idle, done_irq, done_sticky, fetch_valid, fetch_err;
  logic [47:0] fetch_data;

  kernel_boot_loader #(.N_INSTR(N_INSTR), .ADDR_W(20), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .core_idle(core_idle), .done_irq(done_irq),
    .done_sticky(done_sticky), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_err(fetch_err));

  logic [7:0] img [N_BYTES];
  int total = 0, bad = 0;
  bit finished = 0;

  int m_state = 0, m_bytes = 0;
  bit m_irq = 0, m_fv = 0, m_fe = 0;
  logic [47:0] m_fd = '0;

  function automatic logic [47:0] ref_instr(int k);
    logic [47:0] r;
    for (int j = 0; j < 6; j++) r[j*8 +: 8] = img[6*k + j];
    return r;
  endfunction

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    int idx;
    bit ok;
    @(posedge clk);
    m_irq = 0;
    if (rst) begin
      m_state = 0; m_bytes = 0; m_fv = 0; m_fe = 0; m_fd = '0;
    end else begin
      idx = int'(fetch_addr) - int'(BASE);
      ok = (m_state == 2) && idx >= 0 && idx < N_INSTR;
      m_fv = fetch_req;
      m_fe = fetch_req && !ok;
      m_fd = (fetch_req && ok) ? ref_instr(idx) : '0;
      case (m_state)
        0: if (start) m_state = 1;
        1: if (byte_valid) begin
          m_bytes++;
          if (m_bytes == N_BYTES) begin m_state = 2; m_irq = 1; end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    cmp("R2 R5 R11", "byte_ready", 64'(byte_ready), 64'(m_state == 1));
    cmp("R6", "core_idle", 64'(core_idle), 64'(m_state != 2));
    cmp("R7", "done_sticky", 64'(done_sticky), 64'(m_state == 2));
    cmp("R7", "done_irq", 64'(done_irq), 64'(m_irq));
    cmp("R8", "fetch_valid", 64'(fetch_valid), 64'(m_fv));
    cmp("R9 R10", "fetch_err", 64'(fetch_err), 64'(m_fe));
    cmp("R3 R4 R8", "fetch_data", 64'(fetch_data), 64'(m_fd));
  endtask

  task automatic drive_byte(bit v);
    byte_valid = v;
    byte_data = (m_bytes < N_BYTES) ? img[m_bytes] : 8'hA5;
  endtask

  initial begin
    for (int i = 0; i < N_BYTES; i++) img[i] = 8'($urandom);
    @(negedge clk);
    repeat (3) tick();
    // R1 reset state while reset is held
    cmp("R1", "reset outputs", {58'b0, byte_ready, core_idle, done_irq, done_sticky, fetch_valid, fetch_err},
        64'h10);
    cmp("R1", "reset fetch_data", 64'(fetch_data), 64'h0);
    rst = 1'b0;
    // R2: bytes offered before start are not taken; R9: early fetches
    for (int i = 0; i < 6; i++) begin
      drive_byte(1'b1);
      fetch_req = 1'b1; fetch_addr = BASE + 20'(i);
      tick();
    end
    fetch_req = 1'b0;
    start = 1'b1; drive_byte(1'b0); tick(); start = 1'b0;
    // R4: random stalls, R11: stray start mid-load, R9 early fetches
    for (int c = 0; c < 20000 && m_state == 1; c++) begin
      drive_byte(($urandom % 4) != 0);
      start = (c == 100 || c == 777);
      fetch_req = ($urandom % 8) == 0;
      fetch_addr = BASE + 20'($urandom % N_INSTR);
      tick();
    end
    start = 1'b0; fetch_req = 1'b0;
    cmp("R5", "bytes taken", 64'(m_bytes), 64'(N_BYTES));
    // R5 extra bytes ignored, R11 start after done ignored
    for (int i = 0; i < 4; i++) begin
      byte_valid = 1'b1; byte_data = 8'($urandom); start = (i == 1);
      tick();
    end
    byte_valid = 1'b0; start = 1'b0;
    // R8 fetch every instruction
    for (int k = 0; k < N_INSTR; k++) begin
      fetch_req = 1'b1; fetch_addr = BASE + 20'(k);
      tick();
      fetch_req = (k % 5) == 0 ? 1'b0 : 1'b1;
      if (!fetch_req) tick();
    end
    // R10 out-of-range addresses
    fetch_req = 1'b1; fetch_addr = BASE - 20'd1; tick();
    fetch_addr = BASE + 20'(N_INSTR); tick();
    fetch_addr = 20'h0; tick();
    fetch_addr = BASE + 20'(N_INSTR - 1); tick();
    fetch_req = 1'b0; tick(); tick();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule